// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port

This block is a parallel I/O port of the kind found in small 8-bit controllers. Each pin has one output latch bit. Writing 0 to a latch bit turns on that pin's pull-down. Writing 1 releases the pin, so an outside source may drive it and the pin can serve as an input. The pad cell takes two enables per pin from the block: a drive-low enable and a weak pull-up enable. The pad cell returns the sampled level of each pin.

The processor side has two separate read paths. The pin path returns the synchronized external levels, masked by the pull-down of each pin. The latch path returns the stored latch byte. Read-modify-write operations (AND, OR, increment) always start from the latch, never from the pins, and write their result back into the latch. A build parameter selects one of two modes. In pull-up mode, each released pin is held high by a weak internal pull-up. In open-drain mode there is no internal pull-up, so a released pin floats unless the board provides a pull-up.

Top module: `qb_port`

## Requirements
- R1: After reset every latch bit is 1. This gives `pad_drive_low` all zeros and, in pull-up mode, `pad_pullup_en` all ones. `rd_valid` is 0 and `rd_data` is 0.
- R2: When `wr_en` is sampled high, the latch takes `wr_data` at that edge. From then on, `pad_drive_low` is the bitwise inverse of the latch. In pull-up mode, `pad_pullup_en` equals the latch.
- R3: In open-drain mode (`OPEN_DRAIN`=1), `pad_pullup_en` is always all zeros. `pad_drive_low` still follows the inverse of the latch.
- R4: When `rmw_en` is high, `wr_en` is low and `rmw_op` is 2'b00, the latch becomes latch AND `rmw_operand`.
- R5: `rmw_op` 2'b01 sets the latch to latch OR `rmw_operand`. `rmw_op` 2'b10 sets it to latch + 1, wrapping from all ones to zero. `rmw_op` 2'b11 leaves the latch unchanged.
- R6: If `wr_en` and `rmw_en` are high in the same cycle, the plain write wins and the modify operation is dropped.
- R7: A `rd_latch_en` strobe sampled at an edge returns the latch value held before that edge. The value appears on `rd_data` after the edge, with `rd_valid` high. A write in the same cycle therefore does not show in that read.
- R8: A `rd_pin_en` strobe returns the synchronized pin level ANDed with the latch, so a pin whose latch is 0 reads 0. A pad level present at edge k is returned by pin strobes sampled at edge k+2 or later. A strobe sampled at edge k+1 still returns the level from before edge k.
- R9: When both read strobes are high in the same cycle, the pin path is returned.
- R10: In a cycle with no read strobe, `rd_valid` is 0 after the next edge and `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the latch |
| wr_data | input | WIDTH | Byte to write into the latch |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 2 | Modify operation: 00 AND, 01 OR, 10 increment, 11 keep |
| rmw_operand | input | WIDTH | Operand for AND and OR |
| rd_pin_en | input | 1 | Read strobe for the pin path |
| rd_latch_en | input | 1 | Read strobe for the latch path |
| rd_data | output | WIDTH | Returned read byte |
| rd_valid | output | 1 | High for one cycle after a read strobe |
| pad_in | input | WIDTH | Sampled pad levels |
| pad_drive_low | output | WIDTH | Per-pin pull-down enable |
| pad_pullup_en | output | WIDTH | Per-pin weak pull-up enable |

## Verification
A latch update from a write or a modify operation appears on the pad enables after the edge that samples the strobe. A read result appears after the edge that samples its strobe, which is one register stage. A pad change needs two synchronizer stages before a pin read can capture it. The bench drives inputs on falling edges and compares on the falling edge after the edge that produces each result. For the synchronizer it checks two reads on consecutive edges and expects the old level on the first and the new level on the second. To check that a write is not seen in a read of the same cycle, it issues the latch read in the same cycle as the write and compares the result with the old byte.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_INC  = 2'b10,
        OP_KEEP = 2'b11
    } rmw_op_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_operand,
    output logic [WIDTH-1:0] latch_q
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } lat_t;

    lat_t    st_d, st_q;
    rmw_op_e op;

    assign op = rmw_op_e'(rmw_op);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = wr_data;
        end else if (rmw_en) begin
            unique case (op)
                OP_AND:  st_d.bits = st_q.bits & rmw_operand;
                OP_OR:   st_d.bits = st_q.bits | rmw_operand;
                OP_INC:  st_d.bits = st_q.bits + WIDTH'(1);
                default: st_d.bits = st_q.bits;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign latch_q = st_q.bits;
endmodule

// File: rtl/qbp_readback.sv
module qbp_readback #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    input  logic [WIDTH-1:0] pin_level,
    input  logic [WIDTH-1:0] latch_val,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             valid;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d       = rb_q;
        rb_d.valid = rd_pin_en | rd_latch_en;
        if (rd_pin_en)        rb_d.data = pin_level & latch_val;
        else if (rd_latch_en) rb_d.data = latch_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rd_data  = rb_q.data;
    assign rd_valid = rb_q.valid;
endmodule

// File: rtl/qbp_padctl.sv
module qbp_padctl #(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [WIDTH-1:0] latch_val,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] pullup_en
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        assign drive_low[b] = ~latch_val[b];
        if (OPEN_DRAIN) begin : g_od
            assign pullup_en[b] = 1'b0;
        end else begin : g_pu
            assign pullup_en[b] = latch_val[b];
        end
    end
endmodule

// File: rtl/qb_port.sv
module qb_port #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_operand,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_drive_low,
    output logic [WIDTH-1:0] pad_pullup_en
);
    logic [WIDTH-1:0] latch_w;
    logic [WIDTH-1:0] pin_sync_w;

    qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync_w)
    );

    qbp_latch #(.WIDTH(WIDTH)) latch_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
        .latch_q(latch_w)
    );

    qbp_readback #(.WIDTH(WIDTH)) rb_i (
        .clk(clk), .rst_n(rst_n),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
        .pin_level(pin_sync_w), .latch_val(latch_w),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    qbp_padctl #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) pad_i (
        .latch_val(latch_w), .drive_low(pad_drive_low), .pullup_en(pad_pullup_en)
    );
endmodule

// File: rtl/qbp_checker.sv
module qbp_checker #(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rmw_en,
    input logic [1:0]       rmw_op,
    input logic [WIDTH-1:0] rmw_operand,
    input logic             rd_pin_en,
    input logic             rd_latch_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_valid,
    input logic [WIDTH-1:0] pad_drive_low,
    input logic [WIDTH-1:0] pad_pullup_en
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pad_drive_low == ~$past(wr_data)); // R2
    AST_NO_PULLUP_OD: assert property (@(posedge clk) disable iff (!rst_n)
        OPEN_DRAIN |-> pad_pullup_en == '0); // R3
    AST_AND_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_en && !wr_en && rmw_op == 2'b00) |=>
        pad_drive_low == ~(~$past(pad_drive_low) & $past(rmw_operand))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rmw_en) |=> $stable(pad_drive_low)); // R5
    AST_LATCH_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch_en && !rd_pin_en) |=> rd_valid && rd_data == ~$past(pad_drive_low)); // R7
    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pin_en |=> rd_valid && (rd_data & $past(pad_drive_low)) == '0); // R8
    AST_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pin_en && !rd_latch_en) |=> !rd_valid && $stable(rd_data)); // R10
endmodule

bind qb_port qbp_checker #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en)
);

// File: tb/qb_port_tb.sv
module qb_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rmw_en = 1'b0, rd_pin_en = 1'b0, rd_latch_en = 1'b0;
    logic [W-1:0] wr_data = '0, rmw_operand = '0, pad_in = '0;
    logic [1:0] rmw_op = 2'b11;
    logic [W-1:0] rd_data, pad_drive_low, pad_pullup_en;
    logic rd_valid;
    logic [W-1:0] od_rd_data, od_drive_low, od_pullup_en;
    logic od_rd_valid;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qb_port #(.WIDTH(W), .OPEN_DRAIN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .pad_in(pad_in),
        .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en)
    );

    qb_port #(.WIDTH(W), .OPEN_DRAIN(1'b1)) dut_od_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
        .rd_data(od_rd_data), .rd_valid(od_rd_valid), .pad_in(pad_in),
        .pad_drive_low(od_drive_low), .pad_pullup_en(od_pullup_en)
    );

    // {is_write, data/operand, rmw_op, expected latch afterwards}
    typedef struct packed {
        logic         is_wr;
        logic [W-1:0] data;
        logic [1:0]   op;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 8'hA5, 2'b11, 8'hA5},
        '{1'b0, 8'h0F, 2'b00, 8'h05},
        '{1'b0, 8'h30, 2'b01, 8'h35},
        '{1'b0, 8'h00, 2'b10, 8'h36},
        '{1'b1, 8'hFF, 2'b11, 8'hFF},
        '{1'b0, 8'h00, 2'b10, 8'h00},
        '{1'b0, 8'h12, 2'b11, 8'h00},
        '{1'b0, 8'h81, 2'b01, 8'h81},
        '{1'b0, 8'hF0, 2'b00, 8'h80}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic idle();
        wr_en = 1'b0; rmw_en = 1'b0; rd_pin_en = 1'b0; rd_latch_en = 1'b0;
    endtask

    task automatic write_latch(input logic [W-1:0] v);
        @(negedge clk); idle(); wr_en = 1'b1; wr_data = v;
        @(negedge clk); idle();
    endtask

    task automatic read_latch(input string req, input logic [W-1:0] exp);
        @(negedge clk); idle(); rd_latch_en = 1'b1;
        @(negedge clk); idle();
        check(req, W'(rd_valid), W'(1));
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", pad_drive_low, 8'h00);
        check("R1", pad_pullup_en, 8'hFF);
        check("R1", rd_data, 8'h00);
        check("R1", W'(rd_valid), W'(0));
        read_latch("R1", 8'hFF);

        // R2 R4 R5 table walk
        foreach (VECS[i]) begin
            @(negedge clk); idle();
            if (VECS[i].is_wr) begin
                wr_en = 1'b1; wr_data = VECS[i].data;
            end else begin
                rmw_en = 1'b1; rmw_op = VECS[i].op; rmw_operand = VECS[i].data;
            end
            @(negedge clk); idle();
            check(VECS[i].is_wr ? "R2" : (VECS[i].op == 2'b00 ? "R4" : "R5"),
                  pad_drive_low, ~VECS[i].exp);
            check("R2", pad_pullup_en, VECS[i].exp);
            check("R3", od_pullup_en, 8'h00);
            check("R3", od_drive_low, ~VECS[i].exp);
            rd_latch_en = 1'b1;
            @(negedge clk); idle();
            check("R7", rd_data, VECS[i].exp);
        end

        // R7 write and latch read in the same cycle returns the old byte
        @(negedge clk); idle(); wr_en = 1'b1; wr_data = 8'h3C; rd_latch_en = 1'b1;
        @(negedge clk); idle();
        check("R7", rd_data, 8'h80);
        read_latch("R7", 8'h3C);

        // R6 write beats modify
        @(negedge clk); idle();
        wr_en = 1'b1; wr_data = 8'h55; rmw_en = 1'b1; rmw_op = 2'b01; rmw_operand = 8'hFF;
        @(negedge clk); idle();
        read_latch("R6", 8'h55);

        // R8 pin read through released pins
        write_latch(8'hFF);
        pad_in = 8'h5A;
        repeat (4) @(negedge clk);
        @(negedge clk); rd_pin_en = 1'b1;
        @(negedge clk); idle();
        check("R8", rd_data, 8'h5A);

        // R8 synchronizer latency: old value at k+1, new at k+2
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk); rd_pin_en = 1'b1;
        @(negedge clk);
        check("R8", rd_data, 8'h5A);
        @(negedge clk); idle();
        check("R8", rd_data, 8'hC3);

        // R9 both strobes: pin path wins
        @(negedge clk); rd_pin_en = 1'b1; rd_latch_en = 1'b1;
        @(negedge clk); idle();
        check("R9", rd_data, 8'hC3);

        // R10 no strobe: valid low, data held
        @(negedge clk);
        check("R10", W'(rd_valid), W'(0));
        check("R10", rd_data, 8'hC3);

        // R8 pull-down dominates an externally high pin
        write_latch(8'h0F);
        pad_in = 8'hFF;
        repeat (4) @(negedge clk);
        @(negedge clk); rd_pin_en = 1'b1;
        @(negedge clk); idle();
        check("R8", rd_data, 8'h0F);
        check("R3", od_rd_data, 8'h0F);

        // R5 increment wraps
        write_latch(8'hFF);
        @(negedge clk); rmw_en = 1'b1; rmw_op = 2'b10;
        @(negedge clk); idle();
        read_latch("R5", 8'h00);

        summary();
    end
endmodule